// File: doc/BRIEF.md
# Receive Frame Error Statistics Counters

This block sits after a receive MAC datapath. For every finished frame it gets a one-cycle completion pulse and the frame's status: the byte length, a CRC-mismatch flag and a framing (dribble) flag. It puts the frame into zero or more error categories and increments the counter for each category. A frame is counted whether the datapath kept it or dropped it. Short frames and overlong frames are recognised by comparing the length with two parameterised limits. A CRC mismatch is counted as a plain CRC error or as an alignment error, depending on the framing flag.

The three error counters that the CRC and length checks feed are 16 bits wide. They are read one byte per access. The first access returns the upper byte and freezes the counter. The second access returns the lower byte and restarts the counter, so a wide count can be read over a narrow path without tearing. The oversize counter is 8 bits wide and is read in one access. It stays frozen for the two cycles that a read takes. Each counter remembers one increment that arrived while it was frozen, so a read never drops an event completely.

Top module: `rxc_err_stats`

## Requirements
- R1: A completed frame with the CRC flag set and the framing flag clear increments the CRC counter (select 0) by one.
- R2: A completed frame with both the CRC flag and the framing flag set increments the alignment counter (select 1) and leaves the CRC counter unchanged. A frame with only the framing flag set increments neither of them.
- R3: A completed frame whose length is below 64 bytes increments the runt counter (select 2). This happens in addition to any CRC or alignment increment for the same frame. A 64-byte frame is not a runt.
- R4: A completed frame whose length is above 1518 bytes increments the oversize counter (select 3). A 1518-byte frame is not oversize.
- R5: A read strobe at a clock edge makes rd_valid high in the following cycle, with rd_data holding the selected byte. In every cycle with no strobe at the previous edge, rd_valid is low.
- R6: Reading a 16-bit counter takes two accesses to the same select. The first returns bits 15:8 and the second returns bits 7:0. After the second access the counter is zero.
- R7: Between the two accesses of a 16-bit read the counter value does not change. This includes frames that arrive in the same cycle as either strobe. If any such frame arrived, the counter holds 1 after the second access instead of 0.
- R8: A 16-bit counter stops at 0xFFFF and does not wrap.
- R9: An oversize read returns the 8-bit count, zero-extended. The counter clears to 0 at the clock edge after the strobe.
- R10: An oversize frame that arrives in the strobe cycle or the following cycle of an oversize read does not change the value returned. After that read completes, the counter holds 1.
- R11: The oversize counter stops at 0xFF and does not wrap.
- R12: Reset clears every counter, every freeze state and rd_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_done | input | 1 | One-cycle pulse when a frame's status is valid |
| frame_len | input | 16 | Frame length in bytes |
| crc_err | input | 1 | Frame failed its CRC check |
| frame_err | input | 1 | Frame ended on a non-byte boundary |
| rd_strobe | input | 1 | Read access request |
| rd_sel | input | 2 | Counter select: 0 CRC, 1 alignment, 2 runt, 3 oversize |
| rd_valid | output | 1 | Read data valid, one cycle after the strobe |
| rd_data | output | 8 | Byte returned by the read |

## Verification
The oversize-read properties rely on two things about the inputs. First, strobes that select the oversize counter are at least two cycles apart. Second, the cycle just before the earlier of two compared reads carries no strobe, so that earlier read really starts a freeze rather than landing on a completion edge. The testbench meets both conditions. After every oversize read it leaves one idle cycle. It places oversize frames in the strobe cycle or the completion cycle only on purpose, to exercise the pending-increment rule. Wide-counter reads are always issued in high/low pairs to the same select, so the freeze state the bench expects always matches the design's.

// File: rtl/rxc_pkg.sv
package rxc_pkg;

    typedef enum logic [1:0] {
        SEL_CRC   = 2'd0,
        SEL_ALIGN = 2'd1,
        SEL_RUNT  = 2'd2,
        SEL_OVS   = 2'd3
    } rxc_sel_e;

    localparam int NUM_WIDE = 3;
    localparam int NUM_CAT  = 4;
    localparam int SEL_W    = 2;

endpackage

// File: rtl/rxc_classify.sv
module rxc_classify #(
    parameter int LEN_W   = 16,
    parameter int MIN_LEN = 64,
    parameter int MAX_LEN = 1518
) (
    input  logic                          done_i,
    input  logic [LEN_W-1:0]              len_i,
    input  logic                          crc_i,
    input  logic                          ferr_i,
    output logic [rxc_pkg::NUM_CAT-1:0]   hit_o
);
    import rxc_pkg::*;

    localparam logic [LEN_W-1:0] MIN_L = LEN_W'(MIN_LEN);
    localparam logic [LEN_W-1:0] MAX_L = LEN_W'(MAX_LEN);

    always_comb begin
        hit_o            = '0;
        hit_o[SEL_CRC]   = done_i && crc_i && !ferr_i;
        hit_o[SEL_ALIGN] = done_i && crc_i && ferr_i;
        hit_o[SEL_RUNT]  = done_i && (len_i < MIN_L);
        hit_o[SEL_OVS]   = done_i && (len_i > MAX_L);
    end

endmodule

// File: rtl/rxc_wide_ctr.sv
module rxc_wide_ctr #(
    parameter int CW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc_i,
    input  logic              rd_i,
    output logic [CW/2-1:0]   byte_o
);
    localparam int HALF = CW / 2;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          frozen;
        logic          pend;
    } wst_t;

    wst_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd_i) begin
            if (!st_q.frozen) begin
                // upper byte taken: hold value, remember same-edge event
                st_d.frozen = 1'b1;
                st_d.pend   = inc_i;
            end else begin
                // lower byte taken: restart, keeping one missed event
                st_d.frozen = 1'b0;
                st_d.pend   = 1'b0;
                st_d.cnt    = (st_q.pend || inc_i) ? CW'(1) : '0;
            end
        end else if (inc_i) begin
            if (st_q.frozen) begin
                st_d.pend = 1'b1;
            end else if (st_q.cnt != {CW{1'b1}}) begin
                st_d.cnt = st_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign byte_o = st_q.frozen ? st_q.cnt[HALF-1:0] : st_q.cnt[CW-1:HALF];

endmodule

// File: rtl/rxc_snap_ctr.sv
module rxc_snap_ctr #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc_i,
    input  logic          rd_i,
    output logic [CW-1:0] value_o
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          busy;
        logic          pend;
    } sst_t;

    sst_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.busy) begin
            // read completes this edge
            st_d.busy = 1'b0;
            st_d.pend = 1'b0;
            st_d.cnt  = (st_q.pend || inc_i) ? CW'(1) : '0;
        end else if (rd_i) begin
            st_d.busy = 1'b1;
            st_d.pend = inc_i;
        end else if (inc_i && (st_q.cnt != {CW{1'b1}})) begin
            st_d.cnt = st_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign value_o = st_q.cnt;

endmodule

// File: rtl/rxc_err_stats.sv
module rxc_err_stats #(
    parameter int LEN_W   = 16,
    parameter int MIN_LEN = 64,
    parameter int MAX_LEN = 1518,
    parameter int WIDE_W  = 16,
    parameter int OVS_W   = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frame_done,
    input  logic [LEN_W-1:0]     frame_len,
    input  logic                 crc_err,
    input  logic                 frame_err,
    input  logic                 rd_strobe,
    input  logic [1:0]           rd_sel,
    output logic                 rd_valid,
    output logic [WIDE_W/2-1:0]  rd_data
);
    import rxc_pkg::*;

    localparam int DATA_W = WIDE_W / 2;

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
    } rsp_t;

    logic [NUM_CAT-1:0] hit;
    logic [DATA_W-1:0]  wide_byte [NUM_WIDE];
    logic [OVS_W-1:0]   ovs_val;
    rsp_t               rsp_d, rsp_q;

    rxc_classify #(
        .LEN_W   (LEN_W),
        .MIN_LEN (MIN_LEN),
        .MAX_LEN (MAX_LEN)
    ) u_cls (
        .done_i (frame_done),
        .len_i  (frame_len),
        .crc_i  (crc_err),
        .ferr_i (frame_err),
        .hit_o  (hit)
    );

    for (genvar i = 0; i < NUM_WIDE; i++) begin : g_wide
        rxc_wide_ctr #(.CW(WIDE_W)) u_ctr (
            .clk    (clk),
            .rst_n  (rst_n),
            .inc_i  (hit[i]),
            .rd_i   (rd_strobe && (rd_sel == SEL_W'(i))),
            .byte_o (wide_byte[i])
        );
    end

    rxc_snap_ctr #(.CW(OVS_W)) u_ovs (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc_i   (hit[SEL_OVS]),
        .rd_i    (rd_strobe && (rd_sel == SEL_OVS)),
        .value_o (ovs_val)
    );

    always_comb begin
        rsp_d.valid = rd_strobe;
        rsp_d.data  = rsp_q.data;
        if (rd_strobe) begin
            case (rxc_sel_e'(rd_sel))
                SEL_CRC:   rsp_d.data = wide_byte[0];
                SEL_ALIGN: rsp_d.data = wide_byte[1];
                SEL_RUNT:  rsp_d.data = wide_byte[2];
                default:   rsp_d.data = DATA_W'(ovs_val);
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rd_valid = rsp_q.valid;
    assign rd_data  = rsp_q.data;

endmodule

// File: rtl/rxc_err_stats_chk.sv
module rxc_err_stats_chk #(
    parameter int LEN_W   = 16,
    parameter int MAX_LEN = 1518,
    parameter int DATA_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_done,
    input logic [LEN_W-1:0]  frame_len,
    input logic              rd_strobe,
    input logic [1:0]        rd_sel,
    input logic              rd_valid,
    input logic [DATA_W-1:0] rd_data
);
    logic ovs_hit;
    logic ovs_rd;
    assign ovs_hit = frame_done && (frame_len > LEN_W'(MAX_LEN));
    assign ovs_rd  = rd_strobe && (rd_sel == 2'd3);

    // R5
    rd_valid_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe |=> rd_valid);

    // R5
    rd_valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_strobe |=> !rd_valid);

    // R10
    ovs_pending_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovs_rd && !$past(rd_strobe) && $past(ovs_rd, 2) && !$past(rd_strobe, 3)
         && $past(ovs_hit, 2)) |=> (rd_data == DATA_W'(1)));

    // R9
    ovs_clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovs_rd && !$past(rd_strobe) && $past(ovs_rd, 2) && !$past(rd_strobe, 3)
         && !$past(ovs_hit, 2) && !$past(ovs_hit)) |=> (rd_data == '0));

endmodule

bind rxc_err_stats rxc_err_stats_chk #(
    .LEN_W   (LEN_W),
    .MAX_LEN (MAX_LEN),
    .DATA_W  (DATA_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_done (frame_done),
    .frame_len  (frame_len),
    .rd_strobe  (rd_strobe),
    .rd_sel     (rd_sel),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data)
);

// File: tb/rxc_err_stats_test.sv
`timescale 1ns/100ps
module rxc_err_stats_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_done = 1'b0;
    logic [15:0] frame_len = '0;
    logic        crc_err = 1'b0;
    logic        frame_err = 1'b0;
    logic        rd_strobe = 1'b0;
    logic [1:0]  rd_sel = '0;
    logic        rd_valid;
    logic [7:0]  rd_data;

    int checks = 0;
    int fails  = 0;
    int exp_q[$];
    string tag_q[$];
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    rxc_err_stats uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_done (frame_done),
        .frame_len  (frame_len),
        .crc_err    (crc_err),
        .frame_err  (frame_err),
        .rd_strobe  (rd_strobe),
        .rd_sel     (rd_sel),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data)
    );

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // monitor: pop expected bytes as responses appear
    always @(negedge clk) begin
        if (rst_n && rd_valid && !finished) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R5 unexpected response", 1, 0);
            end else begin
                automatic int e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(rd_data == e[7:0], t, rd_data, e);
            end
        end
    end

    task automatic set_frame(int len, bit c, bit f);
        frame_done = 1'b1;
        frame_len  = len[15:0];
        crc_err    = c;
        frame_err  = f;
    endtask

    task automatic clr_frame();
        frame_done = 1'b0;
        crc_err    = 1'b0;
        frame_err  = 1'b0;
    endtask

    task automatic burst(int n, int len, bit c, bit f);
        set_frame(len, c, f);
        repeat (n) @(negedge clk);
        clr_frame();
    endtask

    task automatic rd(int sel, int exp, string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        rd_strobe = 1'b1;
        rd_sel    = sel[1:0];
        @(negedge clk);
        rd_strobe = 1'b0;
        if (sel == 3) @(negedge clk);
    endtask

    task automatic rd_with_frame(int sel, int exp, string tag, int len, bit c, bit f);
        set_frame(len, c, f);
        rd(sel, exp, tag);
        clr_frame();
    endtask

    initial begin
        repeat (190000) @(negedge clk);
        if (!finished) begin
            check(1'b0, "watchdog", 0, 1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset state
        check(rd_valid == 1'b0, "R12 rd_valid in reset", rd_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        rd(0, 8'h00, "R12 crc hi"); rd(0, 8'h00, "R12 crc lo");
        rd(1, 8'h00, "R12 align hi"); rd(1, 8'h00, "R12 align lo");
        rd(2, 8'h00, "R12 runt hi"); rd(2, 8'h00, "R12 runt lo");
        rd(3, 8'h00, "R12 ovs");
        // R5: no strobe, no valid
        check(rd_valid == 1'b0, "R5 idle after read", rd_valid, 0);

        // classification patterns
        burst(1, 100, 1, 0);   // R1 crc
        burst(1, 100, 1, 1);   // R2 align
        burst(1, 100, 0, 1);   // R2 framing only: nothing
        burst(1, 64, 0, 0);    // R3 boundary: not runt
        burst(1, 63, 0, 0);    // R3 runt
        burst(1, 10, 1, 0);    // R3 runt + crc
        burst(1, 1518, 0, 0);  // R4 boundary: not oversize
        burst(1, 1519, 0, 0);  // R4 oversize
        burst(1, 30, 1, 1);    // R3 runt + align
        rd(0, 8'h00, "R1 crc hi"); rd(0, 8'h02, "R1 crc lo");
        rd(1, 8'h00, "R2 align hi"); rd(1, 8'h02, "R2 align lo");
        rd(2, 8'h00, "R3 runt hi"); rd(2, 8'h03, "R3 runt lo");
        rd(3, 8'h01, "R4 ovs");
        rd(3, 8'h00, "R9 ovs cleared");

        // R6: byte order and clear
        burst(300, 200, 1, 0);
        rd(0, 8'h01, "R6 hi byte"); rd(0, 8'h2C, "R6 lo byte");
        rd(0, 8'h00, "R6 cleared hi"); rd(0, 8'h00, "R6 cleared lo");

        // R7: freeze between accesses
        burst(5, 200, 1, 0);
        rd(0, 8'h00, "R7 hi");
        burst(3, 200, 1, 0);
        rd(0, 8'h05, "R7 frozen lo");
        rd(0, 8'h00, "R7 pending hi"); rd(0, 8'h01, "R7 pending lo");
        burst(2, 200, 1, 1);
        rd_with_frame(1, 8'h00, "R7 same-edge hi", 200, 1, 1);
        rd(1, 8'h02, "R7 same-edge lo");
        rd(1, 8'h00, "R7 same-edge pend hi"); rd(1, 8'h01, "R7 same-edge pend lo");

        // R8: 16-bit saturation
        burst(65540, 5, 0, 0);
        rd(2, 8'hFF, "R8 sat hi"); rd(2, 8'hFF, "R8 sat lo");
        rd(2, 8'h00, "R8 after hi"); rd(2, 8'h00, "R8 after lo");

        // R11: 8-bit saturation
        burst(300, 2000, 0, 0);
        rd(3, 8'hFF, "R11 ovs sat");
        rd(3, 8'h00, "R11 ovs cleared");

        // R10: increment in strobe cycle
        burst(4, 2000, 0, 0);
        rd_with_frame(3, 8'h04, "R10 strobe-cycle value", 2000, 0, 0);
        rd(3, 8'h01, "R10 strobe-cycle pending");
        rd(3, 8'h00, "R9 clear after pending");

        // R10: increment in completion cycle
        burst(2, 2000, 0, 0);
        exp_q.push_back(8'h02);
        tag_q.push_back("R10 completion-cycle value");
        rd_strobe = 1'b1;
        rd_sel    = 2'd3;
        @(negedge clk);
        rd_strobe = 1'b0;
        set_frame(2000, 0, 0);
        @(negedge clk);
        clr_frame();
        @(negedge clk);
        rd(3, 8'h01, "R10 completion-cycle pending");

        // R12: reset mid-run
        burst(3, 200, 1, 0);
        burst(2, 2000, 0, 0);
        rd(0, 8'h00, "R12 pre-reset hi");
        rst_n = 1'b0;
        @(negedge clk);
        check(rd_valid == 1'b0, "R12 rd_valid after reset", rd_valid, 0);
        exp_q.delete();
        tag_q.delete();
        rst_n = 1'b1;
        @(negedge clk);
        rd(0, 8'h00, "R12 crc hi after reset"); rd(0, 8'h00, "R12 crc lo after reset");
        rd(3, 8'h00, "R12 ovs after reset");

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R5 all responses seen", exp_q.size(), 0);
        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule